// File: doc/BRIEF.md
# Interrupt Mask Register Unit

This block keeps the 64-bit mask state of an interrupt controller and updates it from a simple memory-mapped write port. A set mask bit blocks the matching interrupt source. Software can change the mask in three ways:

- Replace either 32-bit half with a full-word write.
- Write a byte to a set-shortcut register, which raises one mask bit chosen by a 6-bit index, or every bit when its all-bits flag is set.
- Write a byte to a clear-shortcut register, which lowers one mask bit the same way, or every bit.

The block also combines 64 pending request lines with the mask. It raises a single flag whenever some unmasked request is present. A write to an offset the block does not decode leaves the mask untouched and raises a one-cycle error pulse.

Reads use the same address bus. They are combinational and return one half of the mask, or zero for any other offset.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset all 64 mask bits are one and `wr_err` is low.
- R2: A write to offset 0x0C loads `bus_wdata` into mask bits 31:0 and keeps bits 63:32, with the new value visible after that clock edge.
- R3: A write to offset 0x08 loads `bus_wdata` into mask bits 63:32 and keeps bits 31:0.
- R4: A write to offset 0x1C with data bit 6 set makes all 64 mask bits one.
- R5: A write to offset 0x1C with data bit 6 clear sets only the mask bit indexed by data bits 5:0. Data bits 31:7 are ignored.
- R6: A write to offset 0x1D with data bit 6 set makes all 64 mask bits zero.
- R7: A write to offset 0x1D with data bit 6 clear clears only the mask bit indexed by data bits 5:0. Data bits 31:7 are ignored.
- R8: A write to any other offset leaves the mask unchanged and drives `wr_err` high for exactly the one cycle after that edge.
- R9: `bus_rdata` combinationally returns mask bits 63:32 for offset 0x08, bits 31:0 for offset 0x0C, and zero for every other offset, including 0x1C and 0x1D.
- R10: `irq_active` is combinationally high exactly when some bit i has `pend_in[i]` = 1 and mask bit i = 0.
- R11: When `bus_wr` is low, neither the mask nor `wr_err` changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data; the shortcut registers use bits 6:0 |
| bus_rdata | output | 32 | Combinational read data |
| pend_in | input | 64 | Pending interrupt request lines |
| mask_out | output | 64 | Current mask, where 1 means masked |
| irq_active | output | 1 | Some unmasked request is pending |
| wr_err | output | 1 | One-cycle pulse after a write to an undecoded offset |

## Verification
The mask is driven through several patterns, and each one separates a different fault:

- Half-word writes use asymmetric values, which exposes a swapped or merged half.
- Shortcut writes use indices 0, 37 and 63, which catch an index off by one or an index truncated at the half boundary.
- Shortcut writes with bit 7 set show that the upper data bits are ignored.
- The all-bits forms are applied from a mixed mask, so they cannot look correct by chance.
- Pending patterns are placed on masked bits only, on a single unmasked bit, and on none. This separates an inverted mask sense from a missing term in the reduction.
- Undecoded offsets next to the valid ones (0x10, 0x1E) and writes with the strobe low show that nothing leaks into the mask.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    // Write command decoded from one bus cycle
    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_LOAD_LO,
        CMD_LOAD_HI,
        CMD_SET_BIT,
        CMD_CLR_BIT,
        CMD_BAD
    } mask_cmd_e;

    localparam int OFS_HI  = 'h08;
    localparam int OFS_LO  = 'h0C;
    localparam int OFS_SET = 'h1C;
    localparam int OFS_CLR = 'h1D;

    // Position of the all-bits flag inside a shortcut byte
    localparam int ALL_FLAG_BIT = 6;

endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output mask_cmd_e         cmd
);
    always_comb begin
        cmd = CMD_IDLE;
        if (wr) begin
            if (addr == ADDR_W'(OFS_LO))       cmd = CMD_LOAD_LO;
            else if (addr == ADDR_W'(OFS_HI))  cmd = CMD_LOAD_HI;
            else if (addr == ADDR_W'(OFS_SET)) cmd = CMD_SET_BIT;
            else if (addr == ADDR_W'(OFS_CLR)) cmd = CMD_CLR_BIT;
            else                               cmd = CMD_BAD;
        end
    end
endmodule

// File: rtl/irqm_mask_next.sv
module irqm_mask_next
    import irqm_pkg::*;
#(
    parameter int NSRC = 64,
    localparam int HALF  = NSRC / 2,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  mask_cmd_e         cmd,
    input  logic [HALF-1:0]   wdata,
    input  logic [NSRC-1:0]   mask_cur,
    output logic [NSRC-1:0]   mask_nxt
);
    logic             all_flag;
    logic [IDX_W-1:0] bit_idx;

    assign all_flag = wdata[ALL_FLAG_BIT];
    assign bit_idx  = wdata[IDX_W-1:0];

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic hit;
        logic half_val;

        assign hit = all_flag || (bit_idx == IDX_W'(i));

        if (i < HALF) begin : g_lo
            assign half_val = wdata[i];
        end else begin : g_hi
            assign half_val = wdata[i-HALF];
        end

        always_comb begin
            mask_nxt[i] = mask_cur[i];
            case (cmd)
                CMD_LOAD_LO: if (i < HALF)  mask_nxt[i] = half_val;
                CMD_LOAD_HI: if (i >= HALF) mask_nxt[i] = half_val;
                CMD_SET_BIT: if (hit)       mask_nxt[i] = 1'b1;
                CMD_CLR_BIT: if (hit)       mask_nxt[i] = 1'b0;
                default:     mask_nxt[i] = mask_cur[i];
            endcase
        end
    end
endmodule

// File: rtl/irqm_pending.sv
module irqm_pending #(
    parameter int NSRC = 64
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] mask,
    output logic            any_active
);
    logic [NSRC-1:0] live;

    assign live       = pend & ~mask;
    assign any_active = |live;
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
    import irqm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NSRC   = 64,
    localparam int HALF  = NSRC / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [HALF-1:0]   bus_wdata,
    output logic [HALF-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   pend_in,
    output logic [NSRC-1:0]   mask_out,
    output logic              irq_active,
    output logic              wr_err
);
    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic            err;
    } state_t;

    state_t    st_d, st_q;
    mask_cmd_e cmd;
    logic [NSRC-1:0] mask_nxt;

    irqm_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .cmd  (cmd)
    );

    irqm_mask_next #(.NSRC(NSRC)) u_next (
        .cmd      (cmd),
        .wdata    (bus_wdata),
        .mask_cur (st_q.mask),
        .mask_nxt (mask_nxt)
    );

    irqm_pending #(.NSRC(NSRC)) u_pend (
        .pend       (pend_in),
        .mask       (st_q.mask),
        .any_active (irq_active)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = mask_nxt;
        st_d.err  = (cmd == CMD_BAD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_HI))      bus_rdata = st_q.mask[NSRC-1:HALF];
        else if (bus_addr == ADDR_W'(OFS_LO)) bus_rdata = st_q.mask[HALF-1:0];
    end

    assign mask_out = st_q.mask;
    assign wr_err   = st_q.err;

    // R2: a low-half write lands in the low half and keeps the high half
    p_lo_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_LO)) |=>
            (mask_out[HALF-1:0] == $past(bus_wdata)) &&
            (mask_out[NSRC-1:HALF] == $past(mask_out[NSRC-1:HALF])));

    // R3: a high-half write lands in the high half and keeps the low half
    p_hi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_HI)) |=>
            (mask_out[NSRC-1:HALF] == $past(bus_wdata)) &&
            (mask_out[HALF-1:0] == $past(mask_out[HALF-1:0])));

    // R4: the set shortcut with the all-bits flag masks every source
    p_set_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_SET) && bus_wdata[ALL_FLAG_BIT]) |=>
            (mask_out == '1));

    // R6: the clear shortcut with the all-bits flag unmasks every source
    p_clr_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR) && bus_wdata[ALL_FLAG_BIT]) |=>
            (mask_out == '0));

    // R8: an error pulse always comes with an unchanged mask
    p_err_keeps_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $stable(mask_out));

    // R11: with the write strobe low, the mask holds and no error appears
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(mask_out) && !wr_err));
endmodule

// File: tb/test_irq_mask_unit.sv
module test_irq_mask_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] pend_in;
    logic [63:0] mask_out;
    logic        irq_active;
    logic        wr_err;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [63:0] m_mask;
    logic        m_err;

    always #10 clk = ~clk;

    irq_mask_unit i_irq_mask_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pend_in    (pend_in),
        .mask_out   (mask_out),
        .irq_active (irq_active),
        .wr_err     (wr_err)
    );

    function automatic void cmp(input string req, input string what,
                                input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h08) return m_mask[63:32];
        if (a == 8'h0C) return m_mask[31:0];
        return 32'h0;
    endfunction

    // One bus cycle: drive at the falling edge, check combinational outputs,
    // advance the model at the rising edge, check registered outputs after it.
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                        input logic [63:0] p, input string req);
        bus_addr  = a;
        bus_wr    = w;
        bus_wdata = d;
        pend_in   = p;
        #2;
        cmp("R9", {req, " rdata"}, {32'h0, bus_rdata}, {32'h0, model_read(a)});
        cmp("R10", {req, " irq"}, {63'h0, irq_active}, {63'h0, |(p & ~m_mask)});
        @(posedge clk);
        m_err = 1'b0;
        if (w) begin
            case (a)
                8'h0C: m_mask[31:0]  = d;
                8'h08: m_mask[63:32] = d;
                8'h1C: if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
                8'h1D: if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
                default: m_err = 1'b1;
            endcase
        end
        @(negedge clk);
        cmp(req, "mask", mask_out, m_mask);
        cmp(req, "err", {63'h0, wr_err}, {63'h0, m_err});
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = 8'h0; bus_wr = 1'b0; bus_wdata = '0; pend_in = '0;
        m_mask = '1; m_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cmp("R1", "mask", mask_out, 64'hFFFF_FFFF_FFFF_FFFF);
        cmp("R1", "err", {63'h0, wr_err}, 64'h0);

        // R10: all pending but all masked
        step(8'h00, 1'b0, 32'h0, '1, "R10");
        // R2 / R3 with asymmetric halves, then read both back
        step(8'h0C, 1'b1, 32'hA5A5_0F0F, 64'h0, "R2");
        step(8'h08, 1'b1, 32'h1234_8001, 64'h0, "R3");
        step(8'h0C, 1'b0, 32'h0, 64'h0, "R9");
        step(8'h08, 1'b0, 32'h0, 64'h0, "R9");
        step(8'h1C, 1'b0, 32'h0, 64'h0, "R9");
        step(8'h1D, 1'b0, 32'h0, 64'h0, "R9");
        // R10: pending on an unmasked low bit (bit 4 is 0 in A5A5_0F0F)
        step(8'h00, 1'b0, 32'h0, 64'h10, "R10");
        // R6 from a mixed mask
        step(8'h1D, 1'b1, 32'h40, 64'h0, "R6");
        // R5: indices 0, 37, 63, and one with bit 7 set
        step(8'h1C, 1'b1, 32'h00, 64'h0, "R5");
        step(8'h1C, 1'b1, 32'h25, 64'h0, "R5");
        step(8'h1C, 1'b1, 32'h3F, 64'h0, "R5");
        step(8'h1C, 1'b1, 32'hFFFF_FF85, 64'h0, "R5");
        // R10: pending only on masked bits, then one unmasked
        step(8'h00, 1'b0, 32'h0, 64'h8000_0020_0000_0021, "R10");
        step(8'h00, 1'b0, 32'h0, 64'h0000_0040_0000_0000, "R10");
        // R4 from a mixed mask
        step(8'h1C, 1'b1, 32'h7F, 64'h0, "R4");
        // R7: clear 63, 0, 37, and one with bit 7 set
        step(8'h1D, 1'b1, 32'h3F, 64'h0, "R7");
        step(8'h1D, 1'b1, 32'h00, 64'h0, "R7");
        step(8'h1D, 1'b1, 32'h25, 64'h0, "R7");
        step(8'h1D, 1'b1, 32'h0000_0F9F, 64'h0, "R7");
        step(8'h00, 1'b0, 32'h0, 64'h8000_0000_0000_0000, "R10");
        // R8: undecoded offsets, back to back, then recovery
        step(8'h10, 1'b1, 32'hFFFF_FFFF, 64'h0, "R8");
        step(8'h1E, 1'b1, 32'h0000_0040, 64'h0, "R8");
        step(8'h0C, 1'b0, 32'h0, 64'h0, "R8");
        // R11: strobe low at live offsets
        step(8'h1D, 1'b0, 32'h40, 64'h0, "R11");
        step(8'h0C, 1'b0, 32'h0, 64'h0, "R11");
        step(8'h1C, 1'b0, 32'h40, 64'h0, "R11");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule